// File: doc/BRIEF.md
# Software Write-Protection Command Gate

This block sits in front of a byte-write page controller and decides, write by write, whether an accepted byte write may reach storage. It holds a protection flag that stands in for a nonvolatile bit. While the flag is clear, every write passes. While it is set, writes pass only inside a single page window. That window is opened by a fixed three-write arming command and closed when the page controller reports that the page has finished programming. A fixed six-write command clears the flag.

Each accepted write arrives as a one-cycle strobe carrying an address and a data byte. A small sequence tracker compares each write with the next step expected by either command. When a write is the wrong next step, the tracker falls back to idle. The exception is a write that is itself a valid first step: in that case the tracker restarts one step in. While the flag is set and no window is open, a command byte that matches is reported as suppressed and is not stored, and a byte that matches nothing is discarded silently. The forwarded write and the suppression flag appear one clock after the strobe, and the flag and window state change on that same edge.

Top module: `wprot_gate`

## Requirements
- R1: After reset, protOn equals the PROT_INIT parameter (0 by default), winOpen is 0, and both wrFwd and cmdDrop are 0.
- R2: While protOn is 0, each write strobe gives wrFwd=1 one cycle later with fwdAddr/fwdData equal to the write's address and data, and cmdDrop=0.
- R3: The arming command is three consecutive writes: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. One cycle after the third write, protOn=1 and winOpen=1. This holds whether protOn was 0 or 1 before.
- R4: While winOpen is 1, every write is forwarded. A one-cycle progDone pulse makes winOpen 0 on the next cycle, and protOn stays 1.
- R5: While protOn=1 and winOpen=0, a write that matches the tracker's next expected step, or that is 0xAA at 0x5555, gives cmdDrop=1 and wrFwd=0 one cycle later.
- R6: While protOn=1 and winOpen=0, a write that matches no step gives wrFwd=0 and cmdDrop=0.
- R7: The disarm command is six consecutive writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. One cycle after the sixth write, protOn=0, and later writes are forwarded.
- R8: Any write that breaks a command sequence sends the tracker back to idle, so the command has no effect. A write of 0xAA at 0x5555 restarts the sequence with that write counted as the first step.
- R9: While winOpen is 1, writes are not tracked as commands, so a disarm sequence written inside a window is forwarded as data and leaves protOn at 1.
- R10: protOn changes only when an arming or disarming command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | One-cycle strobe marking an accepted byte write |
| wrAddr | input | ADDR_W | Address of the write |
| wrData | input | DATA_W | Data byte of the write |
| progDone | input | 1 | Pulse from the page controller when page programming ends |
| wrFwd | output | 1 | Write passed on to the page controller (one cycle after the strobe) |
| fwdAddr | output | ADDR_W | Address of the forwarded write |
| fwdData | output | DATA_W | Data of the forwarded write |
| cmdDrop | output | 1 | Command byte suppressed from storage |
| protOn | output | 1 | Protection flag |
| winOpen | output | 1 | Page window open |

## Verification
Every result of a write strobe lands exactly one clock edge after that strobe: wrFwd, fwdAddr, fwdData and cmdDrop, together with the updated protOn and winOpen. The window's closing lands one edge after the progDone pulse. The bench drives each strobe on a falling edge and drops it on the next falling edge, which lies after the single register stage, and it samples every output there. It never samples on a rising edge. The expectations come from the command step tables and from byte arithmetic in the sweeps: a 256-value sweep of the first-step byte, plus corruption of each step of both commands in turn.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_D3,
    ST_D4,
    ST_D5
  } seqState_t;

  typedef struct packed {
    logic fwd;
    logic drop;
    logic arm;
    logic disarm;
  } gateStrobe_t;

  localparam logic [7:0] CODE_LEAD   = 8'hAA;
  localparam logic [7:0] CODE_ECHO   = 8'h55;
  localparam logic [7:0] CODE_ARM    = 8'hA0;
  localparam logic [7:0] CODE_EXT    = 8'h80;
  localparam logic [7:0] CODE_DISARM = 8'h20;

endpackage

// File: rtl/wprot_seq_ctrl.sv
module wprot_seq_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_LEAD = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] ADDR_ECHO = ADDR_W'(15'h2AAA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              protOn,
  input  logic              winOpen,
  output gateStrobe_t       strobe
);

  seqState_t state, nextState;
  logic atLead, atEcho;
  logic isLead, isEcho, isArm, isExt, isDisarm;
  logic tracking, passAll, stepOk, armHit, disarmHit;

  always_comb begin
    atLead   = (wrAddr == ADDR_LEAD);
    atEcho   = (wrAddr == ADDR_ECHO);
    isLead   = atLead && (wrData == DATA_W'(CODE_LEAD));
    isEcho   = atEcho && (wrData == DATA_W'(CODE_ECHO));
    isArm    = atLead && (wrData == DATA_W'(CODE_ARM));
    isExt    = atLead && (wrData == DATA_W'(CODE_EXT));
    isDisarm = atLead && (wrData == DATA_W'(CODE_DISARM));
    tracking = wrValid && !winOpen;
    passAll  = !protOn || winOpen;
  end

  // Step tracker: a wrong step falls back to idle, or to step two on a lead write.
  always_comb begin
    nextState = state;
    stepOk    = 1'b0;
    armHit    = 1'b0;
    disarmHit = 1'b0;
    if (tracking) begin
      nextState = isLead ? ST_U1 : ST_IDLE;
      case (state)
        ST_U1: if (isEcho) begin nextState = ST_U2; stepOk = 1'b1; end
        ST_U2: begin
          if (isArm) begin
            nextState = ST_IDLE; stepOk = 1'b1; armHit = 1'b1;
          end else if (isExt) begin
            nextState = ST_D3; stepOk = 1'b1;
          end
        end
        ST_D3: if (isLead) begin nextState = ST_D4; stepOk = 1'b1; end
        ST_D4: if (isEcho) begin nextState = ST_D5; stepOk = 1'b1; end
        ST_D5: if (isDisarm) begin
          nextState = ST_IDLE; stepOk = 1'b1; disarmHit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.fwd    = wrValid && passAll;
    strobe.drop   = wrValid && !passAll && (stepOk || isLead);
    strobe.arm    = armHit;
    strobe.disarm = disarmHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R9: no command is tracked while a page window is open
  p_idle_in_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    winOpen |-> state == ST_IDLE);

  // R8: a lead write outside a pending lead step restarts at step two
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && isLead && state != ST_D3) |=> state == ST_U1);

endmodule

// File: rtl/wprot_gate_dp.sv
module wprot_gate_dp
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter bit PROT_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  output logic              wrFwd,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              cmdDrop,
  output logic              protOn,
  output logic              winOpen
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protOn  <= PROT_INIT;
      winOpen <= 1'b0;
    end else begin
      if (strobe.arm)         protOn <= 1'b1;
      else if (strobe.disarm) protOn <= 1'b0;
      if (strobe.arm)         winOpen <= 1'b1;
      else if (progDone)      winOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFwd   <= 1'b0;
      cmdDrop <= 1'b0;
      fwdAddr <= '0;
      fwdData <= '0;
    end else begin
      wrFwd   <= strobe.fwd;
      cmdDrop <= strobe.drop;
      if (strobe.fwd) begin
        fwdAddr <= wrAddr;
        fwdData <= wrData;
      end
    end
  end

  p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> (protOn && winOpen));

  p_disarm_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.disarm |=> !protOn);

  p_close_r4: assert property (@(posedge clk) disable iff (!rstN)
    (progDone && winOpen && !strobe.arm) |=> (!winOpen && protOn));

  p_no_leak_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrFwd |-> $past(!protOn || winOpen));

  p_drop_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdDrop |-> !wrFwd);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.arm && !strobe.disarm) |=> $stable(protOn));

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter bit PROT_INIT = 1'b0,
  parameter logic [ADDR_W-1:0] ADDR_LEAD = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] ADDR_ECHO = ADDR_W'(15'h2AAA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  output logic              wrFwd,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              cmdDrop,
  output logic              protOn,
  output logic              winOpen
);

  gateStrobe_t strobe;

  wprot_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_LEAD(ADDR_LEAD), .ADDR_ECHO(ADDR_ECHO)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .protOn(protOn), .winOpen(winOpen), .strobe(strobe)
  );

  wprot_gate_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_INIT(PROT_INIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .progDone(progDone), .wrFwd(wrFwd),
    .fwdAddr(fwdAddr), .fwdData(fwdData), .cmdDrop(cmdDrop),
    .protOn(protOn), .winOpen(winOpen)
  );

endmodule

// File: tb/wprot_gate_tb_top.sv
module wprot_gate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        progDone = 1'b0;
  logic        wrFwd, cmdDrop, protOn, winOpen;
  logic [14:0] fwdAddr;
  logic [7:0]  fwdData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  wprot_gate dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .progDone(progDone), .wrFwd(wrFwd),
    .fwdAddr(fwdAddr), .fwdData(fwdData), .cmdDrop(cmdDrop),
    .protOn(protOn), .winOpen(winOpen)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    progDone = 1'b1;
    @(negedge clk);
    progDone = 1'b0;
  endtask

  function automatic logic [14:0] armA(input int i);
    return (i == 1) ? 15'h2AAA : 15'h5555;
  endfunction
  function automatic logic [7:0] armD(input int i);
    case (i) 0: return 8'hAA; 1: return 8'h55; default: return 8'hA0; endcase
  endfunction
  function automatic logic [14:0] disA(input int i);
    return (i == 1 || i == 4) ? 15'h2AAA : 15'h5555;
  endfunction
  function automatic logic [7:0] disD(input int i);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(protOn == 1'b0, "R1 protOn", 32'(protOn), 0);
    check(winOpen == 1'b0, "R1 winOpen", 32'(winOpen), 0);
    check(!wrFwd && !cmdDrop, "R1 outputs idle", {wrFwd, cmdDrop}, 0);
    rstN = 1'b1;

    // R2 unprotected: every write forwarded
    for (int i = 0; i < 32; i++) begin
      wr(15'(i * 37 + 3), 8'(i));
      check(wrFwd && !cmdDrop, "R2 forward", {wrFwd, cmdDrop}, 2);
      check(fwdAddr == 15'(i * 37 + 3) && fwdData == 8'(i), "R2 payload",
            {fwdAddr, fwdData}, {15'(i * 37 + 3), 8'(i)});
    end

    // R3 arm from unprotected (bytes still forwarded)
    for (int i = 0; i < 3; i++) begin
      wr(armA(i), armD(i));
      check(wrFwd, "R2 command byte forwarded when unprotected", 32'(wrFwd), 1);
    end
    check(protOn && winOpen, "R3 armed from clear", {protOn, winOpen}, 3);

    // R4 window writes pass, then close on progDone
    for (int i = 0; i < 4; i++) begin
      wr(15'h0400 + 15'(i), 8'hC0 + 8'(i));
      check(wrFwd && fwdData == 8'hC0 + 8'(i), "R4 window write", {wrFwd, fwdData},
            {1'b1, 8'hC0 + 8'(i)});
    end
    pulseDone();
    check(!winOpen && protOn, "R4 window closed", {protOn, winOpen}, 2);

    // R5 / R6 sweep of first-step byte at lead address
    for (int d = 0; d < 256; d++) begin
      wr(15'h5555, 8'(d));
      check(!wrFwd && cmdDrop == (d == 8'hAA), "R5 R6 lead sweep",
            {wrFwd, cmdDrop}, {1'b0, d == 8'hAA});
    end
    wr(15'h1234, 8'hAA);
    check(!wrFwd && !cmdDrop, "R6 stray write", {wrFwd, cmdDrop}, 0);

    // R8 arming with one corrupted step has no effect
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 3; i++) wr(armA(i), (i == k) ? armD(i) ^ 8'h01 : armD(i));
      check(protOn && !winOpen, "R8 corrupted arm", {protOn, winOpen}, 2);
    end
    // R8 restart: duplicated lead byte still arms; R3 re-arm while protected
    wr(15'h5555, 8'hAA);
    for (int i = 0; i < 3; i++) begin
      wr(armA(i), armD(i));
      check(cmdDrop && !wrFwd, "R5 arm step dropped", {wrFwd, cmdDrop}, 1);
    end
    check(protOn && winOpen, "R8 restart arms", {protOn, winOpen}, 3);

    // R9 disarm inside a window is plain data
    for (int i = 0; i < 6; i++) begin
      wr(disA(i), disD(i));
      check(wrFwd && !cmdDrop && fwdData == disD(i), "R9 forwarded in window",
            {wrFwd, cmdDrop, fwdData}, {2'b10, disD(i)});
    end
    pulseDone();
    check(protOn && !winOpen, "R9 still protected", {protOn, winOpen}, 2);

    // R8 disarm with one corrupted step has no effect
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 6; i++) wr(disA(i), (i == k) ? disD(i) ^ 8'h01 : disD(i));
      check(protOn, "R8 R10 corrupted disarm", 32'(protOn), 1);
    end

    // R7 full disarm
    for (int i = 0; i < 6; i++) begin
      wr(disA(i), disD(i));
      check(cmdDrop && !wrFwd, "R5 disarm step dropped", {wrFwd, cmdDrop}, 1);
    end
    check(!protOn && !winOpen, "R7 disarmed", {protOn, winOpen}, 0);
    wr(15'h0100, 8'h3C);
    check(wrFwd && fwdAddr == 15'h0100, "R7 write passes after disarm",
          {wrFwd, fwdAddr}, {1'b1, 15'h0100});

    summary();
    $finish;
  end

endmodule